// File: doc/BRIEF.md
# Four-Bit Multi-Function Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for two 4-bit unsigned operands. A 3-bit operation code picks one of six functions: add, subtract, logical right shift by one, full multiply, bitwise XNOR and equality test. Every function drives one common 8-bit result bus. Results narrower than 8 bits are padded with zeros, so no result bit is ever left floating or unknown.

A single carry input feeds the add and subtract paths. For add it is a carry-in. For subtract it is a borrow-in. A single carry output reports the carry of an add or the borrow of a subtract, and reads zero for every other function. The two spare operation codes are defined: they give an all-zero result and a clear carry. Because the unit holds no state, a new operand set shows up on the outputs within the same cycle in which it is applied.

Top module: `alu4_core`

## Requirements
- R1: With op_i = 3'b000 (add), result_o[3:0] equals the low four bits of a_i + b_i + carry_i, result_o[7:4] is zero, and carry_o is bit 4 of that sum.
- R2: With op_i = 3'b001 (subtract), result_o[3:0] equals the low four bits of a_i − b_i − carry_i, result_o[7:4] is zero, and carry_o is 1 exactly when a_i < b_i + carry_i (a borrow).
- R3: With op_i = 3'b010 (shift), result_o equals a_i shifted right by one with a zero entering bit 3, zero-extended to 8 bits, and carry_o is 0.
- R4: With op_i = 3'b011 (multiply), result_o equals the full 8-bit unsigned product a_i × b_i, and carry_o is 0.
- R5: With op_i = 3'b100 (XNOR), result_o[3:0] equals the bitwise XNOR of a_i and b_i, result_o[7:4] is zero, and carry_o is 0.
- R6: With op_i = 3'b101 (equality), result_o is 8'h01 when a_i equals b_i and 8'h00 otherwise, and carry_o is 0.
- R7: With op_i = 3'b110 or 3'b111, result_o is 8'h00 and carry_o is 0.
- R8: For every op_i other than 3'b000 and 3'b001, carry_i has no effect: result_o and carry_o are the same whether carry_i is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand (unsigned) |
| b_i | input | 4 | Second operand (unsigned) |
| carry_i | input | 1 | Carry-in for add, borrow-in for subtract |
| op_i | input | 3 | Operation code |
| result_o | output | 8 | Zero-extended result |
| carry_o | output | 1 | Carry out of add, borrow out of subtract, zero otherwise |

## Verification
The unit holds no state. A fault in an internal ripple stage, a partial-product row or the output select shows up on result_o or carry_o for the very operand set that exercises it, in the same cycle the inputs are applied. A sweep over every operand pair, every carry-in value and every operation code therefore drives each carry chain and each product row through all of its input combinations. The sweep also exposes any pad bit that is not held at zero and any case where carry_i leaks into a function that must ignore it. Directed corner cases, such as a carry or borrow rippling through all four bits and the largest product, are named separately so that a mismatch points straight at its requirement.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int unsigned OPND_W = 4;
    localparam int unsigned SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_SHR  = 3'b010,
        OP_MUL  = 3'b011,
        OP_XNR  = 3'b100,
        OP_EQ   = 3'b101,
        OP_RSV6 = 3'b110,
        OP_RSV7 = 3'b111
    } alu_op_e;

    function automatic logic op_uses_carry(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic op_is_spare(input alu_op_e op);
        return (op == OP_RSV6) || (op == OP_RSV7);
    endfunction

endpackage

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    // Subtract is done as a + ~b + ~cin, so cin serves as a borrow-in.
    logic [W-1:0] b_eff;
    logic [W:0]   chain;

    assign b_eff    = sub ? ~b : b;
    assign chain[0] = sub ? ~cin : cin;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_cell
            assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
            assign chain[i+1] = (a[i] & b_eff[i]) | (a[i] & chain[i]) | (b_eff[i] & chain[i]);
        end
    endgenerate

    // Borrow out is the inverted carry when subtracting.
    assign cout = sub ? ~chain[W] : chain[W];

    logic [W:0] ref_a, ref_b, ref_c, ref_s;
    always_comb begin
        ref_a = {1'b0, a};
        ref_b = {1'b0, b};
        ref_c = {{W{1'b0}}, cin};
        if (sub) begin
            ref_s = ref_a - ref_b - ref_c;
            // R2: difference and borrow agree with unsigned subtraction
            a_r2_sub_value: assert ((sum == ref_s[W-1:0]) && (cout == (ref_a < (ref_b + ref_c))))
                else $error("subtract path mismatch");
        end else begin
            ref_s = ref_a + ref_b + ref_c;
            // R1: sum and carry agree with unsigned addition
            a_r1_add_value: assert ({cout, sum} == ref_s)
                else $error("add path mismatch");
        end
    end

endmodule

// File: rtl/alu4_mult.sv
module alu4_mult #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] pp  [W];
    logic [PW-1:0] acc [W];

    genvar r, k;
    generate
        for (r = 0; r < W; r++) begin : g_pp
            assign pp[r] = b[r] ? ({{W{1'b0}}, a} << r) : '0;
        end

        assign acc[0] = pp[0];

        for (r = 1; r < W; r++) begin : g_row
            logic [PW-1:0] cy;
            assign cy[0] = 1'b0;
            for (k = 0; k < PW; k++) begin : g_bit
                assign acc[r][k] = acc[r-1][k] ^ pp[r][k] ^ cy[k];
                if (k < PW - 1) begin : g_cy
                    assign cy[k+1] = (acc[r-1][k] & pp[r][k]) |
                                     (acc[r-1][k] & cy[k]) |
                                     (pp[r][k] & cy[k]);
                end
            end
        end
    endgenerate

    assign prod = acc[W-1];

    logic [PW-1:0] ref_a, ref_b;
    always_comb begin
        ref_a = {{W{1'b0}}, a};
        ref_b = {{W{1'b0}}, b};
        // R4: array product equals the unsigned product
        a_r4_product: assert (prod == ref_a * ref_b)
            else $error("multiplier mismatch");
    end

endmodule

// File: rtl/alu4_bitops.sv
module alu4_bitops #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] shr,
    output logic [W-1:0] xnr,
    output logic         eq
);
    assign shr = {1'b0, a[W-1:1]};
    assign xnr = ~(a ^ b);
    // Equality reuses the XNOR vector: all bits agree.
    assign eq  = &xnr;

    always_comb begin
        // R5: each XNOR bit is set exactly where the operands agree
        a_r5_xnor_agree: assert ((xnr ^ a ^ b) == {W{1'b1}})
            else $error("xnor mismatch");
        // R6: the equality flag matches operand equality
        a_r6_eq_flag: assert (eq == (a == b))
            else $error("equality mismatch");
    end

endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import alu4_pkg::*;
#(
    parameter int unsigned W = OPND_W
) (
    input  logic [W-1:0]       a_i,
    input  logic [W-1:0]       b_i,
    input  logic               carry_i,
    input  logic [SEL_W-1:0]   op_i,
    output logic [2*W-1:0]     result_o,
    output logic               carry_o
);
    localparam int unsigned RES_W = 2 * W;
    localparam int unsigned PAD_W = RES_W - W;

    typedef struct packed {
        logic [RES_W-1:0] value;
        logic             carry;
    } alu_res_t;

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    logic [W-1:0]     as_sum;
    logic             as_cout;
    logic [RES_W-1:0] mul_prod;
    logic [W-1:0]     sh_val;
    logic [W-1:0]     xn_val;
    logic             eq_flag;

    alu4_addsub #(.W(W)) u_addsub (
        .a    (a_i),
        .b    (b_i),
        .cin  (carry_i),
        .sub  (op == OP_SUB),
        .sum  (as_sum),
        .cout (as_cout)
    );

    alu4_mult #(.W(W)) u_mult (
        .a    (a_i),
        .b    (b_i),
        .prod (mul_prod)
    );

    alu4_bitops #(.W(W)) u_bitops (
        .a   (a_i),
        .b   (b_i),
        .shr (sh_val),
        .xnr (xn_val),
        .eq  (eq_flag)
    );

    alu_res_t sel;
    always_comb begin
        sel = '0;
        unique case (op)
            OP_ADD, OP_SUB: sel = '{value: {{PAD_W{1'b0}}, as_sum}, carry: as_cout};
            OP_SHR:         sel = '{value: {{PAD_W{1'b0}}, sh_val}, carry: 1'b0};
            OP_MUL:         sel = '{value: mul_prod, carry: 1'b0};
            OP_XNR:         sel = '{value: {{PAD_W{1'b0}}, xn_val}, carry: 1'b0};
            OP_EQ:          sel = '{value: {{(RES_W-1){1'b0}}, eq_flag}, carry: 1'b0};
            default:        sel = '0;
        endcase
    end

    assign result_o = sel.value;
    assign carry_o  = sel.carry;

    always_comb begin
        // R8: the carry output only ever rises for add or subtract
        a_r8_carry_arith_only: assert (!carry_o || op_uses_carry(op))
            else $error("carry raised outside add/subtract");
        // R7: spare codes give zero result and clear carry
        a_r7_spare_zero: assert (!op_is_spare(op) || ((result_o == '0) && !carry_o))
            else $error("spare code produced nonzero output");
        // R3: shifted result keeps the padded bits at zero and moves a_i down one place
        a_r3_shift_port: assert ((op != OP_SHR) || (result_o == ({{PAD_W{1'b0}}, a_i} >> 1)))
            else $error("shift result mismatch");
        // R6: equality result is only ever 0 or 1
        a_r6_eq_range: assert ((op != OP_EQ) || (result_o[RES_W-1:1] == '0))
            else $error("compare result out of range");
    end

endmodule

// File: tb/tb_alu4_core.sv
`timescale 1ns/1ps
module tb_alu4_core;

    logic       clk = 1'b0;
    logic [3:0] a_i = '0;
    logic [3:0] b_i = '0;
    logic       carry_i = 1'b0;
    logic [2:0] op_i = '0;
    logic [7:0] result_o;
    logic       carry_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [7:0] q_res [$];
    logic       q_c   [$];
    string      q_tag [$];
    logic [11:0] q_stim [$];

    always #2 clk = ~clk;  // 250 MHz

    alu4_core dut (
        .a_i      (a_i),
        .b_i      (b_i),
        .carry_i  (carry_i),
        .op_i     (op_i),
        .result_o (result_o),
        .carry_o  (carry_o)
    );

    function automatic void model(input logic [3:0] a, input logic [3:0] b, input logic c,
                                  input logic [2:0] op, output logic [7:0] r, output logic co);
        logic [4:0] t;
        r  = 8'h00;
        co = 1'b0;
        case (op)
            3'b000: begin
                t  = {1'b0, a} + {1'b0, b} + {4'b0, c};
                r  = {4'h0, t[3:0]};
                co = t[4];
            end
            3'b001: begin
                t  = {1'b0, a} - {1'b0, b} - {4'b0, c};
                r  = {4'h0, t[3:0]};
                co = ({1'b0, a} < ({1'b0, b} + {4'b0, c}));
            end
            3'b010: r = {5'b0, a[3:1]};
            3'b011: r = {4'b0, a} * {4'b0, b};
            3'b100: r = {4'h0, ~(a ^ b)};
            3'b101: r = (a == b) ? 8'h01 : 8'h00;
            default: begin r = 8'h00; co = 1'b0; end
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic c);
        if (c && (op != 3'b000) && (op != 3'b001)) return "R8";
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b011:  return "R4";
            3'b100:  return "R5";
            3'b101:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic c,
                         input logic [2:0] op, input string tag);
        logic [7:0] er;
        logic       ec;
        @(posedge clk);
        a_i = a; b_i = b; carry_i = c; op_i = op;
        model(a, b, c, op, er, ec);
        q_res.push_back(er);
        q_c.push_back(ec);
        q_tag.push_back(tag);
        q_stim.push_back({op, c, a, b});
    endtask

    // Monitor: sample between driving edges
    initial begin
        forever begin
            @(negedge clk);
            if (q_res.size() > 0) begin
                logic [7:0]  er;
                logic        ec;
                string       tg;
                logic [11:0] st;
                er = q_res.pop_front();
                ec = q_c.pop_front();
                tg = q_tag.pop_front();
                st = q_stim.pop_front();
                checks++;
                if ((result_o !== er) || (carry_o !== ec)) begin
                    failures++;
                    $display("FAIL %s op=%b c=%b a=%h b=%h: actual res=%h carry=%b expected res=%h carry=%b",
                             tg, st[11:9], st[8], st[7:4], st[3:0], result_o, carry_o, er, ec);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Idle state with all inputs zero: add of zeros
        drive(4'h0, 4'h0, 1'b0, 3'b000, "R1");
        // R1 corners: carry out, full ripple with carry-in
        drive(4'hF, 4'h1, 1'b0, 3'b000, "R1");
        drive(4'hF, 4'hF, 1'b1, 3'b000, "R1");
        drive(4'h7, 4'h8, 1'b0, 3'b000, "R1");
        // R2 corners: borrow through all bits, borrow-in
        drive(4'h0, 4'h1, 1'b0, 3'b001, "R2");
        drive(4'h5, 4'h5, 1'b1, 3'b001, "R2");
        drive(4'h9, 4'h3, 1'b0, 3'b001, "R2");
        // R3
        drive(4'hF, 4'h0, 1'b0, 3'b010, "R3");
        // R4: largest product
        drive(4'hF, 4'hF, 1'b0, 3'b011, "R4");
        // R5
        drive(4'hA, 4'h5, 1'b0, 3'b100, "R5");
        // R6 equal and unequal
        drive(4'hC, 4'hC, 1'b0, 3'b101, "R6");
        drive(4'hC, 4'hD, 1'b0, 3'b101, "R6");
        // R7 spare codes
        drive(4'hF, 4'hF, 1'b0, 3'b110, "R7");
        drive(4'hF, 4'hF, 1'b1, 3'b111, "R7");
        // R8: carry_i ignored outside add/subtract
        drive(4'hF, 4'hF, 1'b1, 3'b011, "R8");
        drive(4'h9, 4'h9, 1'b1, 3'b101, "R8");

        // Exhaustive sweep
        for (int op = 0; op < 8; op++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        drive(4'(a), 4'(b), 1'(c), 3'(op), tag_of(3'(op), 1'(c)));
                    end
                end
            end
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule